// File: doc/BRIEF.md
# Rename Table with Producer-Entry Pointers

This block maps every architectural register to the physical tag that will hold its newest value. Each mapping also carries a ready flag and the instruction-window slot of the in-flight instruction that will write that tag. When a source operand is looked up and its ready flag is clear, the caller receives the producer's window slot along with the tag. The issue window can then reach the producer's entry by index and does not need to search for it.

Up to two instructions are renamed per cycle. The two slots form a single rename group, and slot 1 is the younger of the two. A destination write installs the new tag and the inserting instruction's window slot, and it clears the ready flag. A completion broadcast sets the ready flag on every mapping that holds the completing tag. A group may close with a predicted branch, which is taken as the youngest instruction of the group. That branch saves a copy of the whole table, producer slots included, into one of a ring of checkpoint slots. A misprediction copies a saved table back into the live one. Releasing the oldest checkpoint frees its slot when that branch resolves correctly.

The rename group is a valid/ready stream. The group is accepted in a cycle where `ren_valid` and `ren_ready` are both high. `ren_ready` is low in two cases: a misprediction is being applied, or the group carries a branch while every checkpoint slot is occupied. The caller must hold the group until it is accepted. Lookup outputs are combinational from the table in every cycle. Completion, misprediction and release are plain pulses with no back-pressure.

Top module: `rat_prodptr`

## Requirements
- R1: After reset, architectural register i maps to tag i with the ready flag set and producer slot 0, and no checkpoint slot is held.
- R2: In the same cycle, each of the four source lookups (two per slot) returns the tag, the ready flag and the producer slot of the register it names.
- R3: From the next cycle, an accepted slot with its destination enable set installs its tag and producer slot in the named register and clears that register's ready flag. If both slots name the same register, slot 1's write is the one that remains.
- R4: A completion pulse sets the ready flag of every live mapping whose tag equals the completing tag. A lookup made in the same cycle already reports that mapping as ready.
- R5: When slot 1 reads a register that slot 0 writes in the same group, the lookup returns slot 0's new tag and producer slot, with the ready flag clear.
- R6: An accepted group with its branch flag set saves the table as it stands after the group's own writes. The saved copy goes into the slot given by `ren_br_id`, and slots are handed out in ascending ring order modulo the number of slots.
- R7: A group with its branch flag set that arrives while every checkpoint slot is held sees `ren_ready` low. Such a group, like any group that is not accepted, changes no mapping and takes no slot.
- R8: A misprediction pulse naming a held slot replaces the whole live table, tags and producer slots included, with that slot's copy. It frees that slot and every younger slot, and `ren_ready` is low in that cycle.
- R9: A completion pulse also sets the ready flag in every saved copy whose mapping holds the completing tag, so a later restore sees the producer as finished.
- R10: A release pulse frees the oldest held slot. It is ignored when no slot is held or when a misprediction arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename group present |
| ren_ready | output | 1 | Rename group can be accepted |
| ren_br | input | 1 | Group ends in a predicted branch |
| ren_br_id | output | CW | Checkpoint slot the branch will receive |
| ren_srca | input | 2 x AW | First source register per slot |
| ren_srcb | input | 2 x AW | Second source register per slot |
| ren_dst_en | input | 2 | Destination write enable per slot |
| ren_dst_areg | input | 2 x AW | Destination register per slot |
| ren_dst_tag | input | 2 x TAG_W | New tag per slot |
| ren_dst_ent | input | 2 x ENT_W | Window slot of the inserting instruction per slot |
| out_a_tag | output | 2 x TAG_W | First source tag per slot |
| out_a_rdy | output | 2 | First source ready per slot |
| out_a_ent | output | 2 x ENT_W | First source producer slot per slot |
| out_b_tag | output | 2 x TAG_W | Second source tag per slot |
| out_b_rdy | output | 2 | Second source ready per slot |
| out_b_ent | output | 2 x ENT_W | Second source producer slot per slot |
| cmp_valid | input | 1 | Completion broadcast present |
| cmp_tag | input | TAG_W | Completing tag |
| mis_valid | input | 1 | Misprediction, restore a checkpoint |
| mis_id | input | CW | Checkpoint slot to restore |
| rel_valid | input | 1 | Oldest branch resolved correctly |

## Verification
The bench builds the table with 8 architectural registers, 5-bit tags, 4-bit producer slots and only 2 checkpoint slots. The small register count means random destination writes, same-group forwarding and completions on live tags happen often. The two-slot ring fills after two branches. That makes the full-ring stall, the wrap of the slot index and restores that free younger slots appear many times. Because tags are only 5 bits wide, one completing tag can match several live and saved mappings at once.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    RING_HOLD = 2'b00,
    RING_FREE = 2'b01,
    RING_TAKE = 2'b10,
    RING_BOTH = 2'b11
  } ring_op_e;
endpackage

// File: rtl/rat_ckpt_ring.sv
module rat_ckpt_ring #(
  parameter int NC = 4,
  localparam int CW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          rel_req,
  input  logic          restore,
  input  logic [CW-1:0] restore_id,
  output logic [CW-1:0] alloc_id,
  output logic          full,
  output logic          empty
);
  import rat_pkg::*;

  logic [CW-1:0] head, tail;
  logic [CW:0]   cnt;
  ring_op_e      op;

  assign alloc_id = tail;
  assign full     = (cnt == (CW+1)'(NC));
  assign empty    = (cnt == '0);

  always_comb op = ring_op_e'({take, rel_req && !empty});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (restore) begin
      tail <= restore_id;
      cnt  <= {1'b0, CW'(restore_id - head)};
    end else begin
      case (op)
        RING_TAKE: begin
          tail <= tail + 1'b1;
          cnt  <= cnt + 1'b1;
        end
        RING_FREE: begin
          head <= head + 1'b1;
          cnt  <= cnt - 1'b1;
        end
        RING_BOTH: begin
          tail <= tail + 1'b1;
          head <= head + 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_ring_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (CW+1)'(NC));
  p_no_take_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full);
  p_take_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !restore) |=> alloc_id == CW'($past(alloc_id) + 1'b1));
endmodule

// File: rtl/rat_src_read.sv
module rat_src_read #(
  parameter int NA = 16,
  parameter int TW = 7,
  parameter int EW = 5,
  localparam int AW = $clog2(NA)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NA-1:0][TW-1:0]  map_tag,
  input  logic [NA-1:0]          map_rdy,
  input  logic [NA-1:0][EW-1:0]  map_ent,
  input  logic                   cmp_valid,
  input  logic [TW-1:0]          cmp_tag,
  input  logic [AW-1:0]          src,
  input  logic                   fwd_en,
  input  logic [AW-1:0]          fwd_areg,
  input  logic [TW-1:0]          fwd_tag,
  input  logic [EW-1:0]          fwd_ent,
  output logic [TW-1:0]          o_tag,
  output logic                   o_rdy,
  output logic [EW-1:0]          o_ent
);
  logic hit;
  logic woke;

  assign hit  = fwd_en && (fwd_areg == src);
  assign woke = cmp_valid && (map_tag[src] == cmp_tag);

  always_comb begin
    if (hit) begin
      o_tag = fwd_tag;
      o_rdy = 1'b0;
      o_ent = fwd_ent;
    end else begin
      o_tag = map_tag[src];
      o_rdy = map_rdy[src] | woke;
      o_ent = map_ent[src];
    end
  end

  p_fwd_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (!o_rdy && o_tag == fwd_tag));
  p_wake_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !hit && o_tag == cmp_tag) |-> o_rdy);
endmodule

// File: rtl/rat_prodptr.sv
module rat_prodptr #(
  parameter int NUM_AREG = 16,
  parameter int TAG_W    = 7,
  parameter int ENT_W    = 5,
  parameter int NUM_CKPT = 4,
  localparam int AW = $clog2(NUM_AREG),
  localparam int CW = $clog2(NUM_CKPT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ren_valid,
  output logic                  ren_ready,
  input  logic                  ren_br,
  output logic [CW-1:0]         ren_br_id,
  input  logic [1:0][AW-1:0]    ren_srca,
  input  logic [1:0][AW-1:0]    ren_srcb,
  input  logic [1:0]            ren_dst_en,
  input  logic [1:0][AW-1:0]    ren_dst_areg,
  input  logic [1:0][TAG_W-1:0] ren_dst_tag,
  input  logic [1:0][ENT_W-1:0] ren_dst_ent,
  output logic [1:0][TAG_W-1:0] out_a_tag,
  output logic [1:0]            out_a_rdy,
  output logic [1:0][ENT_W-1:0] out_a_ent,
  output logic [1:0][TAG_W-1:0] out_b_tag,
  output logic [1:0]            out_b_rdy,
  output logic [1:0][ENT_W-1:0] out_b_ent,
  input  logic                  cmp_valid,
  input  logic [TAG_W-1:0]      cmp_tag,
  input  logic                  mis_valid,
  input  logic [CW-1:0]         mis_id,
  input  logic                  rel_valid
);
  localparam int NA = NUM_AREG;
  localparam int NC = NUM_CKPT;

  logic [NA-1:0][TAG_W-1:0] map_tag, nxt_tag, sel_tag;
  logic [NA-1:0]            map_rdy, nxt_rdy, sel_rdy;
  logic [NA-1:0][ENT_W-1:0] map_ent, nxt_ent, sel_ent;

  logic [NC-1:0][NA-1:0][TAG_W-1:0] ck_tag;
  logic [NC-1:0][NA-1:0]            ck_rdy;
  logic [NC-1:0][NA-1:0][ENT_W-1:0] ck_ent;

  logic ring_full, ring_empty, acc, take;

  assign ren_ready = !mis_valid && !(ren_br && ring_full);
  assign acc       = ren_valid && ren_ready;
  assign take      = acc && ren_br;

  rat_ckpt_ring #(.NC(NC)) u_ring (
    .clk(clk), .rst_n(rst_n), .take(take),
    .rel_req(rel_valid && !mis_valid), .restore(mis_valid),
    .restore_id(mis_id), .alloc_id(ren_br_id),
    .full(ring_full), .empty(ring_empty)
  );

  assign sel_tag = ck_tag[mis_id];
  assign sel_rdy = ck_rdy[mis_id];
  assign sel_ent = ck_ent[mis_id];

  always_comb begin
    for (int r = 0; r < NA; r++) begin
      nxt_tag[r] = mis_valid ? sel_tag[r] : map_tag[r];
      nxt_ent[r] = mis_valid ? sel_ent[r] : map_ent[r];
      nxt_rdy[r] = (mis_valid ? sel_rdy[r] : map_rdy[r]) |
                   (cmp_valid && (nxt_tag[r] == cmp_tag));
      for (int s = 0; s < 2; s++) begin
        if (acc && ren_dst_en[s] && ren_dst_areg[s] == AW'(r)) begin
          nxt_tag[r] = ren_dst_tag[s];
          nxt_ent[r] = ren_dst_ent[s];
          nxt_rdy[r] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NA; r++) begin
        map_tag[r] <= TAG_W'(r);
        map_rdy[r] <= 1'b1;
        map_ent[r] <= '0;
      end
    end else begin
      map_tag <= nxt_tag;
      map_rdy <= nxt_rdy;
      map_ent <= nxt_ent;
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_ckpt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ck_tag[k] <= '0;
        ck_rdy[k] <= '0;
        ck_ent[k] <= '0;
      end else if (take && ren_br_id == CW'(k)) begin
        ck_tag[k] <= nxt_tag;
        ck_rdy[k] <= nxt_rdy;
        ck_ent[k] <= nxt_ent;
      end else if (cmp_valid) begin
        for (int r = 0; r < NA; r++)
          if (ck_tag[k][r] == cmp_tag) ck_rdy[k][r] <= 1'b1;
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    rat_src_read #(.NA(NA), .TW(TAG_W), .EW(ENT_W)) u_rd_a (
      .clk(clk), .rst_n(rst_n), .map_tag(map_tag), .map_rdy(map_rdy),
      .map_ent(map_ent), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
      .src(ren_srca[s]), .fwd_en((s == 1) && ren_dst_en[0]),
      .fwd_areg(ren_dst_areg[0]), .fwd_tag(ren_dst_tag[0]),
      .fwd_ent(ren_dst_ent[0]), .o_tag(out_a_tag[s]),
      .o_rdy(out_a_rdy[s]), .o_ent(out_a_ent[s])
    );
    rat_src_read #(.NA(NA), .TW(TAG_W), .EW(ENT_W)) u_rd_b (
      .clk(clk), .rst_n(rst_n), .map_tag(map_tag), .map_rdy(map_rdy),
      .map_ent(map_ent), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
      .src(ren_srcb[s]), .fwd_en((s == 1) && ren_dst_en[0]),
      .fwd_areg(ren_dst_areg[0]), .fwd_tag(ren_dst_tag[0]),
      .fwd_ent(ren_dst_ent[0]), .o_tag(out_b_tag[s]),
      .o_rdy(out_b_rdy[s]), .o_ent(out_b_ent[s])
    );
  end

  p_stall_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_br && ring_full) |-> !ren_ready);
  p_restore_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mis_valid |=> (map_tag == $past(sel_tag) && map_ent == $past(sel_ent)));
  p_dst_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ren_dst_en[1]) |=> !map_rdy[$past(ren_dst_areg[1])]);
  p_mis_blocks_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mis_valid |-> !ren_ready);
endmodule

// File: tb/tb_rat_prodptr.sv
module tb_rat_prodptr;
  localparam int NA = 8, TW = 5, EW = 4, NC = 2;
  localparam int AW = $clog2(NA), CW = $clog2(NC);

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic ren_valid, ren_br, cmp_valid, mis_valid, rel_valid, ren_ready;
  logic [CW-1:0] ren_br_id, mis_id;
  logic [1:0][AW-1:0] srca, srcb, dareg;
  logic [1:0] den;
  logic [1:0][TW-1:0] dtag, a_tag, b_tag;
  logic [1:0][EW-1:0] dent, a_ent, b_ent;
  logic [1:0] a_rdy, b_rdy;
  logic [TW-1:0] cmp_tag;

  rat_prodptr #(.NUM_AREG(NA), .TAG_W(TW), .ENT_W(EW), .NUM_CKPT(NC)) dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_br(ren_br), .ren_br_id(ren_br_id), .ren_srca(srca), .ren_srcb(srcb),
    .ren_dst_en(den), .ren_dst_areg(dareg), .ren_dst_tag(dtag),
    .ren_dst_ent(dent), .out_a_tag(a_tag), .out_a_rdy(a_rdy),
    .out_a_ent(a_ent), .out_b_tag(b_tag), .out_b_rdy(b_rdy),
    .out_b_ent(b_ent), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .mis_valid(mis_valid), .mis_id(mis_id), .rel_valid(rel_valid)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int m_tag[NA], m_rdy[NA], m_ent[NA];
  int c_tag[NC][NA], c_rdy[NC][NA], c_ent[NC][NA];
  int q[$];
  int m_tail = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    ren_valid = 0; ren_br = 0; den = 0; cmp_valid = 0; mis_valid = 0;
    rel_valid = 0; mis_id = 0; cmp_tag = 0;
    srca = '0; srcb = '0; dareg = '0; dtag = '0; dent = '0;
  endtask

  task automatic look(string req, int s, int a, int t, int r, int e);
    int et, er, ee;
    if (s == 1 && den[0] && int'(dareg[0]) == a) begin
      et = int'(dtag[0]); er = 0; ee = int'(dent[0]);
    end else begin
      et = m_tag[a]; ee = m_ent[a];
      er = (m_rdy[a] != 0 || (cmp_valid && int'(cmp_tag) == m_tag[a])) ? 1 : 0;
    end
    chk(req, "tag", t, et);
    chk(req, "rdy", r, er);
    chk(req, "ent", e, ee);
  endtask

  task automatic step(string req);
    bit full, exp_rdy, acc, take, rel_ok;
    int n_tag[NA], n_rdy[NA], n_ent[NA];
    #1;
    full = (q.size() == NC);
    exp_rdy = !mis_valid && !(ren_br && full);
    chk(req, "ren_ready", int'(ren_ready), int'(exp_rdy));
    if (ren_br && !full) chk(req, "ren_br_id", int'(ren_br_id), m_tail);
    for (int s = 0; s < 2; s++) begin
      look(req, s, int'(srca[s]), int'(a_tag[s]), int'(a_rdy[s]), int'(a_ent[s]));
      look(req, s, int'(srcb[s]), int'(b_tag[s]), int'(b_rdy[s]), int'(b_ent[s]));
    end
    acc = ren_valid && exp_rdy;
    take = acc && ren_br;
    for (int r = 0; r < NA; r++) begin
      n_tag[r] = mis_valid ? c_tag[mis_id][r] : m_tag[r];
      n_rdy[r] = mis_valid ? c_rdy[mis_id][r] : m_rdy[r];
      n_ent[r] = mis_valid ? c_ent[mis_id][r] : m_ent[r];
      if (cmp_valid && int'(cmp_tag) == n_tag[r]) n_rdy[r] = 1;
    end
    if (acc)
      for (int s = 0; s < 2; s++)
        if (den[s]) begin
          n_tag[dareg[s]] = int'(dtag[s]);
          n_ent[dareg[s]] = int'(dent[s]);
          n_rdy[dareg[s]] = 0;
        end
    for (int k = 0; k < NC; k++)
      for (int r = 0; r < NA; r++)
        if (cmp_valid && int'(cmp_tag) == c_tag[k][r]) c_rdy[k][r] = 1;
    if (take)
      for (int r = 0; r < NA; r++) begin
        c_tag[m_tail][r] = n_tag[r]; c_rdy[m_tail][r] = n_rdy[r];
        c_ent[m_tail][r] = n_ent[r];
      end
    if (mis_valid) begin
      for (int i = 0; i < q.size(); i++)
        if (q[i] == int'(mis_id)) begin
          while (q.size() > i) void'(q.pop_back());
          break;
        end
      m_tail = int'(mis_id);
    end else begin
      rel_ok = rel_valid && q.size() > 0;
      if (take) begin q.push_back(m_tail); m_tail = (m_tail + 1) % NC; end
      if (rel_ok) void'(q.pop_front());
    end
    @(posedge clk);
    for (int r = 0; r < NA; r++) begin
      m_tag[r] = n_tag[r]; m_rdy[r] = n_rdy[r]; m_ent[r] = n_ent[r];
    end
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    idle();
    for (int r = 0; r < NA; r++) begin m_tag[r] = r; m_rdy[r] = 1; m_ent[r] = 0; end
    for (int k = 0; k < NC; k++)
      for (int r = 0; r < NA; r++) begin c_tag[k][r] = 0; c_rdy[k][r] = 0; c_ent[k][r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset mapping; R2 lookup of several registers
    srca[0] = 0; srcb[0] = 3; srca[1] = 5; srcb[1] = 7;
    step("R1");
    srca[0] = 1; srcb[0] = 2; srca[1] = 4; srcb[1] = 6;
    step("R2");
    // R5 slot 1 reads what slot 0 writes; R3 same-register double write
    ren_valid = 1; den = 2'b11; dareg[0] = 3; dtag[0] = 20; dent[0] = 7;
    dareg[1] = 4; dtag[1] = 21; dent[1] = 9; srca[1] = 3; srcb[1] = 4;
    step("R5");
    ren_valid = 1; den = 2'b11; dareg[0] = 6; dtag[0] = 22; dent[0] = 1;
    dareg[1] = 6; dtag[1] = 23; dent[1] = 2;
    step("R3");
    srca[0] = 3; srcb[0] = 4; srca[1] = 6; srcb[1] = 0;
    step("R3");
    // R4 completion bypass and persistence
    cmp_valid = 1; cmp_tag = 20; srca[0] = 3;
    step("R4");
    srca[0] = 3; srcb[0] = 6;
    step("R4");
    // R6 branch checkpoints, R7 full ring stall
    ren_valid = 1; ren_br = 1; den = 2'b01; dareg[0] = 5; dtag[0] = 9; dent[0] = 3;
    step("R6");
    ren_valid = 1; ren_br = 1; den = 2'b01; dareg[0] = 2; dtag[0] = 10; dent[0] = 4;
    step("R6");
    ren_valid = 1; ren_br = 1; den = 2'b01; dareg[0] = 1; dtag[0] = 11; dent[0] = 5;
    step("R7");
    srca[0] = 1; srcb[0] = 2;
    step("R7");
    // R9 completion reaches saved copies, R8 restore
    cmp_valid = 1; cmp_tag = 9;
    step("R9");
    ren_valid = 1; den = 2'b01; dareg[0] = 5; dtag[0] = 30; dent[0] = 14;
    mis_valid = 1; mis_id = 0;
    step("R8");
    srca[0] = 5; srcb[0] = 2; srca[1] = 3;
    step("R8");
    // R10 release oldest, and release when empty
    rel_valid = 1;
    step("R10");
    rel_valid = 1;
    step("R10");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      ren_valid = ($urandom_range(0, 3) != 0);
      ren_br = ($urandom_range(0, 3) == 0);
      for (int s = 0; s < 2; s++) begin
        srca[s] = AW'($urandom_range(0, NA - 1));
        srcb[s] = AW'($urandom_range(0, NA - 1));
        den[s] = $urandom_range(0, 1);
        dareg[s] = AW'($urandom_range(0, NA - 1));
        dtag[s] = TW'($urandom_range(0, (1 << TW) - 1));
        dent[s] = EW'($urandom_range(0, (1 << EW) - 1));
      end
      if ($urandom_range(0, 1) == 1) dareg[1] = dareg[0];
      cmp_valid = ($urandom_range(0, 2) == 0);
      cmp_tag = TW'(m_tag[$urandom_range(0, NA - 1)]);
      rel_valid = ($urandom_range(0, 5) == 0);
      if (q.size() > 0 && $urandom_range(0, 11) == 0) begin
        mis_valid = 1;
        mis_id = CW'(q[$urandom_range(0, q.size() - 1)]);
      end
      step(mis_valid ? "R8" : (ren_br ? "R6" : "R2"));
    end
    finish_run();
  end
endmodule